// File: doc/BRIEF.md
# Dual-Clear Shift-and-Hold Register

This block takes a serial bit stream into a shift register and moves the collected word into a separate storage register that drives the parallel outputs. Each register has its own strobe and its own active-low clear. New bits can therefore be shifted in while the outputs keep showing the previous word. The outputs change only when the storage strobe tells the block to take the new word.

Both strobes are ordinary data inputs that are sampled on the system clock. A register acts on a low-to-high change of its strobe. The last shift stage is brought out as a cascade bit. The cascade bit of one block can feed the serial input of the next block, and the chained blocks then share their strobes and clears. A common use is to drive a wide group of indicator lines from a narrow serial link.

Top module: `dual_clear_shift_hold`

## Requirements
- R1: When the shift strobe is sampled high on a clock edge after it was sampled low, stage 0 takes `ser_in` and each stage i (i ≥ 1) takes the old value of stage i-1, all on that same edge.
- R2: When the storage strobe is sampled high after it was sampled low, every storage bit i takes shift stage i on that edge.
- R3: While `shift_clr_n` is low, the shift register is zero, at once and without waiting for a clock edge. A shift strobe seen during the clear has no effect.
- R4: While `hold_clr_n` is low, the storage register is zero. The shift register keeps its contents, and a storage strobe seen during this clear has no effect.
- R5: A strobe that falls, or that stays high or stays low, leaves its register unchanged.
- R6: `cascade_out` equals the last shift stage (bit WIDTH-1). It follows shift strobes even when no storage strobe occurs.
- R7: When both strobes rise on the same edge, storage captures the shift contents from before that shift. The outputs are therefore one shift behind.
- R8: `par_out` comes only from the storage register. `par_out[0]` is the copy of stage 0, the first stage to receive serial data, and `par_out[WIDTH-1]` is the copy of the last stage.
- R9: When a clear is released while its strobe is already high, the register does not act. Only a later low-to-high change of the strobe takes effect.
- R10: Two blocks chained through `cascade_out` into `ser_in`, with shared strobes and clears, behave as one shift register of twice the width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples both strobes |
| ser_in | input | 1 | Serial data bit |
| shift_strobe | input | 1 | Shift strobe, acts on a rising level |
| shift_clr_n | input | 1 | Asynchronous clear of the shift register, active low |
| hold_strobe | input | 1 | Storage strobe, acts on a rising level |
| hold_clr_n | input | 1 | Asynchronous clear of the storage register, active low |
| par_out | output | WIDTH | Storage register contents |
| cascade_out | output | 1 | Last shift stage |

## Verification
The serial path is checked through `cascade_out` on every shift. A wrong stage order or a dropped bit shows up there within WIDTH shift strobes, before any storage strobe. A fault in the storage path or in the edge detection shows up on `par_out` on the first clock edge after the storage strobe, and the bench checks the edge where the strobe falls as well. Stale edge-detector state after a clear would make the block act once without a new strobe rise. The bench looks for this one clock after the clear is released with the strobe held high.

// File: rtl/dcsh_pkg.sv
`timescale 1ns/1ps
package dcsh_pkg;
    localparam int DEF_WIDTH = 8;

    // Edge-detector state: previously sampled strobe level
    typedef struct packed {
        logic prev;
    } edge_state_t;
endpackage

// File: rtl/dcsh_edge.sv
`timescale 1ns/1ps
module dcsh_edge
    import dcsh_pkg::*;
(
    input  logic clk,
    input  logic clr_n,
    input  logic strobe,
    output logic rise
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = strobe;
        rise      = strobe & ~st_q.prev;
    end

    // Reset to "high" so a strobe already high at clear release is not an edge
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '{prev: 1'b1};
        else        st_q <= st_d;
    end

    // R9: one rise per strobe pulse
    p_single_rise_r9: assert property (@(posedge clk) disable iff (!clr_n)
        rise |=> !rise);
endmodule

// File: rtl/dcsh_shift.sv
`timescale 1ns/1ps
module dcsh_shift #(
    parameter int WIDTH = dcsh_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             advance,
    input  logic             ser,
    output logic [WIDTH-1:0] q
);
    localparam int LAST = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] bits;
    } shift_state_t;

    shift_state_t st_d, st_q;
    logic [WIDTH-1:0] moved;

    assign moved[0] = ser;
    for (genvar i = 1; i <= LAST; i++) begin : g_stage
        assign moved[i] = st_q.bits[i-1];
    end

    always_comb begin
        st_d = st_q;
        if (advance) st_d.bits = moved;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.bits;

    p_head_load_r1: assert property (@(posedge clk) disable iff (!clr_n)
        advance |=> q[0] == $past(ser));
    p_stage_move_r1: assert property (@(posedge clk) disable iff (!clr_n)
        advance |=> q[LAST:1] == $past(q[LAST-1:0]));
    p_shift_idle_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !advance |=> $stable(q));
    p_shift_clear_r3: assert property (@(posedge clk)
        !clr_n |-> q == '0);
endmodule

// File: rtl/dcsh_hold.sv
`timescale 1ns/1ps
module dcsh_hold #(
    parameter int WIDTH = dcsh_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             capture,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    typedef struct packed {
        logic [WIDTH-1:0] word;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (capture) st_d.word = d;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.word;

    p_capture_r2: assert property (@(posedge clk) disable iff (!clr_n)
        capture |=> q == $past(d));
    p_hold_idle_r5: assert property (@(posedge clk) disable iff (!clr_n)
        !capture |=> $stable(q));
    p_hold_clear_r4: assert property (@(posedge clk)
        !clr_n |-> q == '0);
endmodule

// File: rtl/dual_clear_shift_hold.sv
`timescale 1ns/1ps
module dual_clear_shift_hold #(
    parameter int WIDTH = dcsh_pkg::DEF_WIDTH
) (
    input  logic             clk,
    input  logic             ser_in,
    input  logic             shift_strobe,
    input  logic             shift_clr_n,
    input  logic             hold_strobe,
    input  logic             hold_clr_n,
    output logic [WIDTH-1:0] par_out,
    output logic             cascade_out
);
    localparam int LAST = WIDTH - 1;

    logic             shift_rise;
    logic             hold_rise;
    logic [WIDTH-1:0] sr_q;

    dcsh_edge u_shift_edge (
        .clk    (clk),
        .clr_n  (shift_clr_n),
        .strobe (shift_strobe),
        .rise   (shift_rise)
    );

    dcsh_edge u_hold_edge (
        .clk    (clk),
        .clr_n  (hold_clr_n),
        .strobe (hold_strobe),
        .rise   (hold_rise)
    );

    dcsh_shift #(.WIDTH(WIDTH)) u_shift (
        .clk     (clk),
        .clr_n   (shift_clr_n),
        .advance (shift_rise),
        .ser     (ser_in),
        .q       (sr_q)
    );

    dcsh_hold #(.WIDTH(WIDTH)) u_hold (
        .clk     (clk),
        .clr_n   (hold_clr_n),
        .capture (hold_rise),
        .d       (sr_q),
        .q       (par_out)
    );

    assign cascade_out = sr_q[LAST];

    // R7: after a joint strobe, storage sits one shift behind the shift register
    p_one_behind_r7: assert property (@(posedge clk)
        disable iff (!shift_clr_n || !hold_clr_n)
        (shift_rise && hold_rise) |=> par_out[LAST-1:0] == sr_q[LAST:1]);
endmodule

// File: tb/dual_clear_shift_hold_test.sv
`timescale 1ns/1ps
module dual_clear_shift_hold_test;
    localparam int W = 8;

    logic clk = 1'b0;
    logic ser_in = 1'b0, shift_strobe = 1'b0, hold_strobe = 1'b0;
    logic shift_clr_n = 1'b0, hold_clr_n = 1'b0;
    logic [W-1:0] par_a, par_b;
    logic cas_a, cas_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model: 2W-bit chain, two storage words
    logic [2*W-1:0] m_sr = '0;
    logic [W-1:0]   m_ha = '0, m_hb = '0;

    always #2.5 clk = ~clk;

    dual_clear_shift_hold #(.WIDTH(W)) uut (
        .clk(clk), .ser_in(ser_in), .shift_strobe(shift_strobe),
        .shift_clr_n(shift_clr_n), .hold_strobe(hold_strobe),
        .hold_clr_n(hold_clr_n), .par_out(par_a), .cascade_out(cas_a));

    // R10: second block chained on the cascade output
    dual_clear_shift_hold #(.WIDTH(W)) u_tail (
        .clk(clk), .ser_in(cas_a), .shift_strobe(shift_strobe),
        .shift_clr_n(shift_clr_n), .hold_strobe(hold_strobe),
        .hold_clr_n(hold_clr_n), .par_out(par_b), .cascade_out(cas_b));

    function automatic logic [2*W-1:0] next_chain(logic [2*W-1:0] s, logic b);
        return {s[2*W-2:0], b};
    endfunction

    task automatic check_all(string req);
        checks++;
        if (par_a !== m_ha || par_b !== m_hb ||
            cas_a !== m_sr[W-1] || cas_b !== m_sr[2*W-1]) begin
            errors++;
            $display("FAIL %s: par_a=%h par_b=%h cas=%b%b expected par_a=%h par_b=%h cas=%b%b",
                     req, par_a, par_b, cas_b, cas_a, m_ha, m_hb, m_sr[2*W-1], m_sr[W-1]);
        end
    endtask

    // one strobe pulse: high for one clock, then low for one clock
    task automatic pulse(logic sh, logic ho, logic b, string req);
        @(negedge clk);
        shift_strobe = sh; hold_strobe = ho; ser_in = b;
        if (ho) begin m_ha = m_sr[W-1:0]; m_hb = m_sr[2*W-1:W]; end
        if (sh) m_sr = next_chain(m_sr, b);
        @(negedge clk);
        check_all(req);
        shift_strobe = 1'b0; hold_strobe = 1'b0;
        @(negedge clk);
        check_all("R5 falling strobe");
    endtask

    // clear with strobe held high through the release
    task automatic clear_pulse(logic which_shift, string req);
        @(negedge clk);
        if (which_shift) begin shift_clr_n = 1'b0; shift_strobe = 1'b1; m_sr = '0; end
        else begin hold_clr_n = 1'b0; hold_strobe = 1'b1; m_ha = '0; m_hb = '0; end
        #1 check_all(req);
        @(negedge clk);
        check_all(req);
        shift_clr_n = 1'b1; hold_clr_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_all("R9 no edge at clear release");
        shift_strobe = 1'b0; hold_strobe = 1'b0;
        @(negedge clk);
        check_all("R9 strobe drop");
    endtask

    initial begin
        int unused;
        unused = $urandom(32'd4242);
        #1 check_all("reset state R3 R4");
        @(negedge clk);
        shift_clr_n = 1'b1; hold_clr_n = 1'b1;
        @(negedge clk);
        check_all("reset release");

        // R1 R6 R8: shift pattern without storage, outputs stay zero
        for (int i = 0; i < W; i++) pulse(1'b1, 1'b0, (i % 3) != 0, "R1 R6 shift only");
        check_all("R8 outputs only from storage");
        pulse(1'b0, 1'b1, 1'b0, "R2 R8 storage copy");
        for (int i = 0; i < W; i++) pulse(1'b1, 1'b0, i[0], "R10 chain shift");
        pulse(1'b0, 1'b1, 1'b0, "R10 chain storage");
        // R7: simultaneous strobes
        for (int i = 0; i < 4; i++) pulse(1'b1, 1'b1, 1'b1, "R7 joint strobe");
        // R4: storage clear leaves shift register
        clear_pulse(1'b0, "R4 storage clear");
        pulse(1'b0, 1'b1, 1'b0, "R4 shift kept after storage clear");
        // R3: shift clear overrides strobe
        clear_pulse(1'b1, "R3 shift clear");
        pulse(1'b0, 1'b1, 1'b0, "R3 storage of cleared shift");
        // held-high strobe: only the first rise acts (R5)
        @(negedge clk);
        shift_strobe = 1'b1; ser_in = 1'b1; m_sr = next_chain(m_sr, 1'b1);
        repeat (3) @(negedge clk);
        check_all("R5 held strobe");
        shift_strobe = 1'b0;
        @(negedge clk);

        // random mix
        for (int n = 0; n < 600; n++) begin
            int r;
            r = $urandom_range(0, 99);
            if (r < 2) clear_pulse(1'b1, "R3 random clear");
            else if (r < 4) clear_pulse(1'b0, "R4 random clear");
            else pulse(r[0] | r[3], r[1] & r[2], $urandom_range(0, 1) == 1, "R1 R2 R7 random");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule